// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a virtual address into a physical address by walking a three-level page table held in memory. A client presents a virtual address on a request handshake. The walker takes a snapshot of the root-table pointer at that moment. It then issues three dependent reads of 64-bit table entries, one per level, and returns either a physical address or a fault flag on a response handshake.

The virtual address is 43 bits wide. Reading from high to low, it holds a 10-bit first-level index, a 10-bit second-level index, a 10-bit third-level index and a 13-bit page offset. Each entry is 8 bytes, so an 8 KB table page holds 1024 entries. An entry supplies a 32-bit page number. At the first two levels that page number locates the next table. At the last level it becomes the upper part of the 45-bit result. Every level is read with a physical address.

The memory port allows one read in flight at a time. Each level waits for its data before the next address can be formed, so a full walk costs three memory round trips plus one cycle for acceptance and one for the response.

Top module: `ptw_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: The virtual address is split from the most significant bit down: level-1 index in bits [42:33], level-2 index in bits [32:23], level-3 index in bits [22:13], page offset in bits [12:0].
- R3: Each entry read goes to `table_base + index*8`, computed modulo 2^45. For level 1, `table_base` is the value of `root_base` captured in the cycle the request is accepted.
- R4: An entry is valid when bit 0 is 1. Its page number is bits [44:13]. The next level's table base is that page number followed by 13 zero bits. All other entry bits have no effect.
- R5: A walk with no faults makes exactly three reads, in the order level 1, level 2, level 3. Each read appears as a single-cycle `mem_req_valid` pulse. No read is issued while a previous read is still waiting for `mem_rsp_valid`. A response that arrives is used only if it comes at least one cycle after its request pulse.
- R6: When all three entries are valid, the response carries `rsp_fault` = 0 and `rsp_paddr` = {level-3 page number, page offset}.
- R7: An invalid entry at any level ends the walk at once. No further reads are made, and the response carries `rsp_fault` = 1 and `rsp_paddr` = 0.
- R8: A new request is accepted only when the walker is idle. `req_ready` is 0 from acceptance until the response has been taken.
- R9: Once `rsp_valid` is high, it stays high and keeps `rsp_paddr` and `rsp_fault` unchanged until a cycle with `rsp_ready` high. After that cycle the walker is idle.
- R10: Changes on `root_base` after a request has been accepted have no effect on the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 43 | Virtual address to translate |
| root_base | input | 45 | Physical base address of the level-1 table |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Client takes the result |
| rsp_paddr | output | 45 | Translated physical address (0 on fault) |
| rsp_fault | output | 1 | Walk ended on an invalid entry |
| mem_req_valid | output | 1 | One-cycle pulse issuing an entry read |
| mem_req_addr | output | 45 | Physical address of the entry being read |
| mem_rsp_valid | input | 1 | Entry read data present |
| mem_rsp_data | input | 64 | 64-bit table entry |

## Verification
The assertions check the following on every cycle:
- read requests are single-cycle pulses;
- the controller only moves level 1 to level 2 to level 3;
- `req_ready` and `rsp_valid` are never both high;
- a held response stays stable;
- a fault always comes with a zero address.

Some behaviours can only be shown by the bench's scenarios, where a memory model computes expected values:
- the entry addresses and the final physical address, including wrap-around of the base-plus-offset sum;
- that stray entry bits and a changing `root_base` are ignored;
- that a fault at each level stops further reads.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int IDX_W       = 10;
  localparam int OFF_W       = 13;
  localparam int LEVELS      = 3;
  localparam int PPN_W       = 32;
  localparam int PTE_W       = 64;
  localparam int ENTRY_SHIFT = 3;
  localparam int VA_W        = LEVELS*IDX_W + OFF_W;
  localparam int PA_W        = PPN_W + OFF_W;
  localparam int VPN_W       = LEVELS*IDX_W;
  localparam int LVL_W       = $clog2(LEVELS);

  typedef enum logic [2:0] {ST_IDLE, ST_L1, ST_L2, ST_L3, ST_DONE} walk_state_t;

  function automatic logic [PA_W-1:0] entry_addr(input logic [PA_W-1:0] tbl,
                                                 input logic [IDX_W-1:0] idx);
    return tbl + (PA_W'(idx) << ENTRY_SHIFT);
  endfunction

  function automatic logic entry_ok(input logic [PTE_W-1:0] pte);
    return pte[0];
  endfunction

  function automatic logic [PPN_W-1:0] entry_ppn(input logic [PTE_W-1:0] pte);
    return pte[OFF_W +: PPN_W];
  endfunction

  function automatic logic [PA_W-1:0] ppn_to_base(input logic [PPN_W-1:0] ppn);
    return {ppn, {OFF_W{1'b0}}};
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [PPN_W-1:0] ppn,
                                              input logic [OFF_W-1:0] off);
    return {ppn, off};
  endfunction
endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel
  import ptw_pkg::*;
(
  input  logic [VPN_W-1:0] vpn,
  input  logic [LVL_W-1:0] lvl,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] idx_arr [LEVELS];

  // Level 0 takes the most significant index field.
  for (genvar g = 0; g < LEVELS; g++) begin : g_field
    assign idx_arr[g] = vpn[(LEVELS-1-g)*IDX_W +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int k = 0; k < LEVELS; k++)
      if (LVL_W'(k) == lvl) idx = idx_arr[k];
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             rsp_ready,
  input  logic             mem_rsp_valid,
  input  logic             pte_ok,
  output walk_state_t      state,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic             mem_req_valid,
  output logic             accept,
  output logic             pte_take,
  output logic             walk_end,
  output logic [LVL_W-1:0] lvl_idx
);
  walk_state_t state_n;
  logic        issued;
  logic        in_level;

  assign in_level      = (state == ST_L1) || (state == ST_L2) || (state == ST_L3);
  assign req_ready     = (state == ST_IDLE);
  assign rsp_valid     = (state == ST_DONE);
  assign accept        = req_ready && req_valid;
  assign mem_req_valid = in_level && !issued;
  assign pte_take      = in_level && issued && mem_rsp_valid;
  assign walk_end      = pte_take && (!pte_ok || state == ST_L3);

  always_comb begin
    case (state)
      ST_L2:   lvl_idx = LVL_W'(1);
      ST_L3:   lvl_idx = LVL_W'(2);
      default: lvl_idx = '0;
    endcase
  end

  always_comb begin
    state_n = state;
    case (state)
      ST_IDLE: if (accept) state_n = ST_L1;
      ST_L1:   if (pte_take) state_n = pte_ok ? ST_L2 : ST_DONE;
      ST_L2:   if (pte_take) state_n = pte_ok ? ST_L3 : ST_DONE;
      ST_L3:   if (pte_take) state_n = ST_DONE;
      ST_DONE: if (rsp_ready) state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      issued <= 1'b0;
    end else begin
      state <= state_n;
      if (pte_take)           issued <= 1'b0;
      else if (mem_req_valid) issued <= 1'b1;
    end
  end

  assert_req_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);
  assert_l2_after_l1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_L2 && $past(state) != ST_L2) |-> $past(state) == ST_L1);
  assert_l3_after_l2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_L3 && $past(state) != ST_L3) |-> $past(state) == ST_L2);
  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));
  assert_end_gives_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    walk_end |=> rsp_valid);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VA_W-1:0]        req_vaddr,
  input  logic [PA_W-1:0]        root_base,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [PA_W-1:0]        rsp_paddr,
  output logic                   rsp_fault,
  output logic                   mem_req_valid,
  output logic [PA_W-1:0]        mem_req_addr,
  input  logic                   mem_rsp_valid,
  input  logic [PTE_W-1:0]       mem_rsp_data
);
  walk_state_t       state;
  logic              accept, pte_take, walk_end, pte_ok;
  logic [LVL_W-1:0]  lvl_idx;
  logic [IDX_W-1:0]  cur_idx;
  logic [VA_W-1:0]   va_q;
  logic [PA_W-1:0]   base_q;
  logic [PA_W-1:0]   paddr_q;
  logic              fault_q;
  logic [PPN_W-1:0]  pte_ppn;
  logic              unused_pte_bits;

  assign pte_ok          = entry_ok(mem_rsp_data);
  assign pte_ppn         = entry_ppn(mem_rsp_data);
  assign unused_pte_bits = ^{mem_rsp_data[PTE_W-1:PA_W], mem_rsp_data[OFF_W-1:1]};

  ptw_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .rsp_ready     (rsp_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .pte_ok        (pte_ok),
    .state         (state),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .mem_req_valid (mem_req_valid),
    .accept        (accept),
    .pte_take      (pte_take),
    .walk_end      (walk_end),
    .lvl_idx       (lvl_idx)
  );

  ptw_index_sel u_idx (
    .vpn (va_q[VA_W-1:OFF_W]),
    .lvl (lvl_idx),
    .idx (cur_idx)
  );

  assign mem_req_addr = entry_addr(base_q, cur_idx);
  assign rsp_paddr    = paddr_q;
  assign rsp_fault    = fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_q    <= '0;
      base_q  <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
    end else if (accept) begin
      va_q    <= req_vaddr;
      base_q  <= root_base;
      paddr_q <= '0;
      fault_q <= 1'b0;
    end else if (walk_end) begin
      fault_q <= !pte_ok;
      paddr_q <= pte_ok ? join_pa(pte_ppn, va_q[OFF_W-1:0]) : '0;
    end else if (pte_take) begin
      base_q <= ppn_to_base(pte_ppn);
    end
  end

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));
  assert_fault_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> rsp_paddr == '0);
  assert_no_req_when_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready || rsp_valid) |-> !mem_req_valid);
endmodule

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, rsp_valid, rsp_ready, rsp_fault;
  logic [42:0] req_vaddr;
  logic [44:0] root_base, rsp_paddr, mem_req_addr;
  logic        mem_req_valid, mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 0;

  always #5 clk = ~clk;

  ptw_walker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .root_base(root_base), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench view of the address split: level 0 is the top 10 bits.
  function automatic logic [9:0] b_index(input logic [42:0] va, input int l);
    logic [42:0] sh;
    sh = va >> (13 + 10*(2-l));
    return sh[9:0];
  endfunction

  function automatic logic [44:0] b_addr(input logic [44:0] tbl, input logic [9:0] i);
    logic [47:0] sum;
    sum = {3'b0, tbl} + {35'b0, i, 3'b000};
    return sum[44:0];
  endfunction

  function automatic logic [63:0] make_pte(input logic [31:0] ppn, input bit v);
    return {$urandom()[18:0], ppn, $urandom()[11:0], v};
  endfunction

  // fault_lvl: 0..2 makes that level's entry invalid, 3 means no fault.
  task automatic walk(input logic [42:0] va, input logic [44:0] base,
                      input int fault_lvl, input logic [31:0] ppn_last);
    logic [44:0] tbl;
    logic [31:0] ppn;
    logic [44:0] exp_pa;
    logic [44:0] held_pa;
    logic        held_f;
    int          lat, hold;
    tbl = base;
    check(req_ready == 1'b1, "R8 idle ready", 64'(req_ready), 64'd1);
    req_vaddr = va; root_base = base; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_vaddr = {$urandom(), $urandom()};
    for (int l = 0; l < 3; l++) begin
      check(mem_req_valid == 1'b1, "R5 read pulse", 64'(mem_req_valid), 64'd1);
      check(mem_req_addr == b_addr(tbl, b_index(va, l)), "R3 entry address",
            64'(mem_req_addr), 64'(b_addr(tbl, b_index(va, l))));
      lat = 1 + int'($urandom_range(3));
      for (int c = 0; c < lat; c++) begin
        root_base = {$urandom(), $urandom()};  // R10: ignored mid-walk
        req_valid = $urandom_range(1);
        @(negedge clk);
        req_valid = 1'b0;
        check(mem_req_valid == 1'b0 && req_ready == 1'b0, "R5 single outstanding / R8 busy",
              64'({mem_req_valid, req_ready}), 64'd0);
      end
      ppn = (l == 2) ? ppn_last : $urandom();
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = make_pte(ppn, l != fault_lvl);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      if (l == fault_lvl) break;
      tbl = {ppn, 13'b0};  // R4 next base
    end
    exp_pa = (fault_lvl < 3) ? 45'd0 : {ppn_last, va[12:0]};
    check(rsp_valid == 1'b1 && mem_req_valid == 1'b0, "R7 walk ends, no extra read",
          64'({rsp_valid, mem_req_valid}), 64'd2);
    check(rsp_fault == (fault_lvl < 3), (fault_lvl < 3) ? "R7 fault flag" : "R6 no fault",
          64'(rsp_fault), 64'(fault_lvl < 3));
    check(rsp_paddr == exp_pa, (fault_lvl < 3) ? "R7 zero addr" : "R6 paddr R2 R4 R10",
          64'(rsp_paddr), 64'(exp_pa));
    held_pa = rsp_paddr; held_f = rsp_fault;
    hold = int'($urandom_range(3));
    for (int c = 0; c < hold; c++) begin
      @(negedge clk);
      check(rsp_valid && rsp_paddr == held_pa && rsp_fault == held_f, "R9 hold",
            64'(rsp_paddr), 64'(held_pa));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(rsp_valid == 1'b0 && req_ready == 1'b1, "R9 taken then idle",
          64'({rsp_valid, req_ready}), 64'd1);
  endtask

  initial begin
    process::self().srandom(32'd1234);
    rst_n = 1'b0; req_valid = 1'b0; rsp_ready = 1'b0; mem_rsp_valid = 1'b0;
    mem_rsp_data = '0; req_vaddr = '0; root_base = '0;
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_req_valid, "R1 reset state",
          64'({req_ready, rsp_valid, mem_req_valid}), 64'd4);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid && !mem_req_valid, "R1 after reset",
          64'({req_ready, rsp_valid, mem_req_valid}), 64'd4);
    // Directed corners
    walk('0, '0, 3, 32'h0);
    walk({43{1'b1}}, {45{1'b1}}, 3, 32'hFFFF_FFFF);   // wrap of base + idx*8
    walk(43'h155_5555_5555, 45'h0ABC_DEF0_1230, 0, 32'h1);
    walk(43'h2AA_AAAA_AAAA, 45'h1000_0000_0000, 1, 32'h2);
    walk(43'h7FF_0000_1FFF, 45'h0000_0000_2000, 2, 32'h3);
    // Random walks
    for (int n = 0; n < 300; n++) begin
      int f;
      f = ($urandom_range(3) == 0) ? int'($urandom_range(2)) : 3;
      walk({$urandom(), $urandom()}, {$urandom(), $urandom()}, f, $urandom());
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule